// File: doc/BRIEF.md
# Processor Mailbox Register Interface

This block is the processor-facing register slave of a two-queue mailbox. One queue carries words from peripherals to the processor (inbound). The other carries words from the processor towards a channel dispatcher (outbound). Requests arrive on a single-cycle register port: a valid strobe, a write enable, an 8-bit byte offset and a 32-bit write word. Read data and a read-response strobe come back registered, one cycle after the request.

Reads from the pop window remove the oldest inbound word and return it. The processor can also peek at the inbound head, read a status word for either queue, and read or write a small configuration word. Writes to the forwarding window append the word to the outbound queue, which the dispatcher drains through a pop port. A level interrupt tells the processor that inbound data is waiting, gated by a single enable bit. Any access to an offset the block does not decode returns zero, changes nothing, and raises a one-cycle strobe.

Top module: `mbox_regif`

## Requirements
- R1: After synchronous reset, both queues are empty, the interrupt enable is 0, and `irq`, `bad_offset` and `rsp_valid` are low.
- R2: Only word-aligned offsets are decoded. An offset whose two low bits are not 00 counts as undecoded.
- R3: A read at 0x80, 0x84, 0x88 or 0x8C returns the oldest inbound word and removes it. If the inbound queue is empty, the read returns the invalid marker 0xFFFF_FFFF and removes nothing.
- R4: A read at 0x90 returns the oldest inbound word without removing it, or 0xFFFF_FFFF when the queue is empty.
- R5: A status word has bit 31 set when the queue is full, bit 30 set when it is empty, and the fill level in bits 7:0. All other bits are 0. Offset 0x98 gives the inbound status and 0xB8 the outbound status.
- R6: The configuration word at 0x9C reads back the interrupt enable in bit 0 and the data-pending flag in bit 4. Bit 4 is 1 exactly when the inbound queue holds a word, and all other bits read 0. A write to 0x9C changes only the enable, which takes write bit 0.
- R7: `irq` is high in a cycle exactly when, in the previous cycle, the enable was 1 and the inbound queue was non-empty.
- R8: A write at 0x A0, 0xA4, 0xA8 or 0xAC appends the write word to the outbound queue, unless that queue is full, in which case the write is dropped. `out_data` shows the oldest outbound word, `out_pop` removes it, and `out_empty` flags an empty queue.
- R9: A peripheral word presented with `in_push` is appended to the inbound queue when it is not full and dropped when it is. `in_full` flags a full queue.
- R10: Offset 0x94 accepts writes with no effect, and reads there return 0.
- R11: An access at any other offset, or a read of a write-only offset, or a write to a read-only offset, returns 0, changes no state, and makes `bad_offset` high for exactly the cycle after the request.
- R12: Every read request gets `rsp_valid` and its data in the following cycle. A write never raises `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the access |
| req_wdata | input | 32 | Write word |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Registered read data |
| bad_offset | output | 1 | One-cycle strobe for an undecoded access |
| irq | output | 1 | Inbound-data interrupt, level |
| in_push | input | 1 | Peripheral appends `in_data` to the inbound queue |
| in_data | input | 32 | Peripheral word |
| in_full | output | 1 | Inbound queue full |
| out_pop | input | 1 | Dispatcher removes the outbound head |
| out_data | output | 32 | Outbound head word |
| out_empty | output | 1 | Outbound queue empty |

## Verification
The decoder is first tried with a read of every one of the 256 offsets while the queues are empty. This separates decoded from undecoded, aligned from unaligned, and marker-returning from zero-returning reads. A write sweep over all offsets then checks that writes decode to a different set of offsets and that only the forwarding window and the configuration bit change state. The queue sequences are filled past capacity from both sides and drained through all four pop offsets. Together these show FIFO order, the dropped fifth word, and the full and empty status encodings. Enable toggling with written words that have every other bit set shows that only bit 0 is stored and that the interrupt follows enable-and-data one cycle later.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int WORD_W = 32;

  // word indices (byte offset >> 2)
  localparam logic [5:0] WI_POP_LO   = 6'h20;
  localparam logic [5:0] WI_POP_HI   = 6'h23;
  localparam logic [5:0] WI_PEEK     = 6'h24;
  localparam logic [5:0] WI_SENDER   = 6'h25;
  localparam logic [5:0] WI_IN_STAT  = 6'h26;
  localparam logic [5:0] WI_CFG      = 6'h27;
  localparam logic [5:0] WI_FWD_LO   = 6'h28;
  localparam logic [5:0] WI_FWD_HI   = 6'h2B;
  localparam logic [5:0] WI_OUT_STAT = 6'h2E;

  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_PEND_BIT = 4;
  localparam int ST_FULL_BIT  = 31;
  localparam int ST_EMPTY_BIT = 30;
  localparam int ST_LEVEL_W   = 8;

  typedef enum logic [3:0] {
    OP_IDLE,
    OP_POP,
    OP_PEEK,
    OP_SENDER_RD,
    OP_IN_STAT,
    OP_CFG_RD,
    OP_OUT_STAT,
    OP_SENDER_WR,
    OP_CFG_WR,
    OP_FWD,
    OP_BAD
  } mbox_op_e;

  function automatic logic [WORD_W-1:0] pack_status(input logic full,
                                                    input logic empty,
                                                    input logic [ST_LEVEL_W-1:0] level);
    logic [WORD_W-1:0] w;
    w = '0;
    w[ST_FULL_BIT]  = full;
    w[ST_EMPTY_BIT] = empty;
    w[ST_LEVEL_W-1:0] = level;
    return w;
  endfunction

endpackage

// File: rtl/mbox_queue.sv
module mbox_queue #(
  parameter int          W       = 32,
  parameter int          DEPTH   = 4,
  parameter logic [W-1:0] EMPTY_VAL = '1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = empty ? EMPTY_VAL : mem[rd_ptr];

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
(
  input  logic       valid,
  input  logic       write,
  input  logic [7:0] offset,
  output mbox_op_e   op
);
  logic [5:0] widx;
  logic       aligned;

  assign widx    = offset[7:2];
  assign aligned = (offset[1:0] == 2'b00);

  always_comb begin
    op = OP_IDLE;
    if (valid) begin
      op = OP_BAD;
      if (aligned) begin
        if (!write) begin
          if (widx >= WI_POP_LO && widx <= WI_POP_HI) op = OP_POP;
          else if (widx == WI_PEEK)                   op = OP_PEEK;
          else if (widx == WI_SENDER)                 op = OP_SENDER_RD;
          else if (widx == WI_IN_STAT)                op = OP_IN_STAT;
          else if (widx == WI_CFG)                    op = OP_CFG_RD;
          else if (widx == WI_OUT_STAT)               op = OP_OUT_STAT;
        end else begin
          if (widx >= WI_FWD_LO && widx <= WI_FWD_HI) op = OP_FWD;
          else if (widx == WI_SENDER)                 op = OP_SENDER_WR;
          else if (widx == WI_CFG)                    op = OP_CFG_WR;
        end
      end
    end
  end
endmodule

// File: rtl/mbox_regif.sv
module mbox_regif
  import mbox_pkg::*;
#(
  parameter int               IN_DEPTH     = 4,
  parameter int               OUT_DEPTH    = 4,
  parameter logic [31:0]      INVALID_WORD = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        bad_offset,
  output logic        irq,
  input  logic        in_push,
  input  logic [31:0] in_data,
  output logic        in_full,
  input  logic        out_pop,
  output logic [31:0] out_data,
  output logic        out_empty
);
  localparam int IN_CW  = $clog2(IN_DEPTH+1);
  localparam int OUT_CW = $clog2(OUT_DEPTH+1);

  mbox_op_e op;

  logic [WORD_W-1:0] in_head;
  logic [IN_CW-1:0]  in_count;
  logic              in_empty;
  logic [OUT_CW-1:0] out_count;
  logic              out_full;
  logic              in_pop_req, out_push_req;
  logic              cfg_en;
  logic [WORD_W-1:0] cfg_word, in_status, out_status, rd_val;

  mbox_decode u_dec (
    .valid  (req_valid),
    .write  (req_write),
    .offset (req_addr),
    .op     (op)
  );

  assign in_pop_req   = (op == OP_POP);
  assign out_push_req = (op == OP_FWD);

  mbox_queue #(.W(WORD_W), .DEPTH(IN_DEPTH), .EMPTY_VAL(INVALID_WORD)) u_inq (
    .clk       (clk),
    .rst       (rst),
    .push      (in_push),
    .push_data (in_data),
    .pop       (in_pop_req),
    .head      (in_head),
    .count     (in_count),
    .full      (in_full),
    .empty     (in_empty)
  );

  mbox_queue #(.W(WORD_W), .DEPTH(OUT_DEPTH), .EMPTY_VAL(INVALID_WORD)) u_outq (
    .clk       (clk),
    .rst       (rst),
    .push      (out_push_req),
    .push_data (req_wdata),
    .pop       (out_pop),
    .head      (out_data),
    .count     (out_count),
    .full      (out_full),
    .empty     (out_empty)
  );

  always_comb begin
    cfg_word = '0;
    cfg_word[CFG_EN_BIT]   = cfg_en;
    cfg_word[CFG_PEND_BIT] = !in_empty;
  end

  assign in_status  = pack_status(in_full, in_empty, ST_LEVEL_W'(in_count));
  assign out_status = pack_status(out_full, out_empty, ST_LEVEL_W'(out_count));

  always_comb begin
    case (op)
      OP_POP, OP_PEEK: rd_val = in_head;
      OP_IN_STAT:      rd_val = in_status;
      OP_OUT_STAT:     rd_val = out_status;
      OP_CFG_RD:       rd_val = cfg_word;
      default:         rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_en     <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      bad_offset <= 1'b0;
      irq        <= 1'b0;
    end else begin
      if (op == OP_CFG_WR) cfg_en <= req_wdata[CFG_EN_BIT];
      rsp_valid  <= req_valid && !req_write;
      rsp_rdata  <= rd_val;
      bad_offset <= (op == OP_BAD);
      irq        <= cfg_en && !in_empty;
    end
  end
endmodule

// File: rtl/mbox_regif_chk.sv
module mbox_regif_chk #(
  parameter int          IN_DEPTH     = 4,
  parameter int          OUT_DEPTH    = 4,
  parameter logic [31:0] INVALID_WORD = 32'hFFFF_FFFF
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_write,
  input logic [7:0]  req_addr,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic        bad_offset,
  input logic        irq,
  input logic        in_push,
  input logic        in_full,
  input logic        out_pop,
  input logic        out_empty
);
  int in_lvl, out_lvl;
  logic rd, wr, pop_off, fwd_off, known;

  assign rd      = req_valid && !req_write;
  assign wr      = req_valid && req_write;
  assign pop_off = (req_addr == 8'h80) || (req_addr == 8'h84) ||
                   (req_addr == 8'h88) || (req_addr == 8'h8C);
  assign fwd_off = (req_addr == 8'hA0) || (req_addr == 8'hA4) ||
                   (req_addr == 8'hA8) || (req_addr == 8'hAC);
  assign known   = rd ? (pop_off || req_addr == 8'h90 || req_addr == 8'h94 ||
                         req_addr == 8'h98 || req_addr == 8'h9C || req_addr == 8'hB8)
                      : (fwd_off || req_addr == 8'h94 || req_addr == 8'h9C);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_lvl  <= 0;
      out_lvl <= 0;
    end else begin
      in_lvl  <= in_lvl + ((in_push && in_lvl != IN_DEPTH) ? 1 : 0)
                        - ((rd && pop_off && in_lvl != 0) ? 1 : 0);
      out_lvl <= out_lvl + ((wr && fwd_off && out_lvl != OUT_DEPTH) ? 1 : 0)
                         - ((out_pop && out_lvl != 0) ? 1 : 0);
    end
  end

  AST_IN_FULL_FLAG: assert property (@(posedge clk) disable iff (rst)
    in_full == (in_lvl == IN_DEPTH)); // R9
  AST_OUT_EMPTY_FLAG: assert property (@(posedge clk) disable iff (rst)
    out_empty == (out_lvl == 0)); // R8
  AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(in_lvl != 0)); // R7
  AST_EMPTY_POP_MARKER: assert property (@(posedge clk) disable iff (rst)
    (rd && pop_off && in_lvl == 0) |=> (rsp_rdata == INVALID_WORD)); // R3
  AST_RSP_ONLY_READS: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(rd)); // R12
  AST_BAD_STROBE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !known) |=> bad_offset); // R11
  AST_BAD_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    bad_offset |-> $past(req_valid)); // R11
  AST_SENDER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd && req_addr == 8'h94) |=> (rsp_rdata == 32'h0)); // R10
endmodule

bind mbox_regif mbox_regif_chk #(
  .IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH), .INVALID_WORD(INVALID_WORD)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .bad_offset(bad_offset), .irq(irq), .in_push(in_push), .in_full(in_full),
  .out_pop(out_pop), .out_empty(out_empty)
);

// File: tb/mbox_regif_test.sv
`timescale 1ns/1ps
module mbox_regif_test;
  localparam logic [31:0] INV = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, bad_offset, irq, in_full, out_empty;
  logic [31:0] rsp_rdata, out_data;
  logic        in_push = 1'b0, out_pop = 1'b0;
  logic [31:0] in_data = '0;

  int total = 0;
  int bad = 0;
  logic [31:0] r_data;
  logic        r_valid, r_bad;

  always #2 clk = ~clk;

  mbox_regif uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .bad_offset(bad_offset), .irq(irq),
    .in_push(in_push), .in_data(in_data), .in_full(in_full),
    .out_pop(out_pop), .out_data(out_data), .out_empty(out_empty)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic access(input logic w, input logic [7:0] off, input logic [31:0] d);
    req_valid = 1'b1; req_write = w; req_addr = off; req_wdata = d;
    @(posedge clk); #1;
    r_data = rsp_rdata; r_valid = rsp_valid; r_bad = bad_offset;
    req_valid = 1'b0; req_write = 1'b0;
    @(negedge clk);
  endtask

  task automatic push_in(input logic [31:0] d);
    in_push = 1'b1; in_data = d;
    @(posedge clk); #1;
    in_push = 1'b0;
    @(negedge clk);
  endtask

  task automatic pop_out();
    out_pop = 1'b1;
    @(posedge clk); #1;
    out_pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_irq(input string tag, input logic exp);
    @(posedge clk); #1;
    chk(tag, {31'h0, irq}, {31'h0, exp});
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 bad_offset", {31'h0, bad_offset}, 32'h0);
    chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk("R1 in_full", {31'h0, in_full}, 32'h0);
    chk("R1 out_empty", {31'h0, out_empty}, 32'h1);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // read sweep, both queues empty, enable 0 (R2 R3 R4 R5 R10 R11 R12)
    for (int off = 0; off < 256; off++) begin
      logic [31:0] exp_d;
      logic        exp_b;
      int          wi;
      wi = off >> 2;
      exp_b = 1'b0; exp_d = 32'h0;
      if (off % 4 != 0)                exp_b = 1'b1;
      else if (wi >= 32 && wi <= 36)   exp_d = INV;
      else if (wi == 37)               exp_d = 32'h0;
      else if (wi == 38 || wi == 46)   exp_d = 32'h4000_0000;
      else if (wi == 39)               exp_d = 32'h0;
      else                             exp_b = 1'b1;
      access(1'b0, 8'(off), 32'h0);
      chk($sformatf("R11 R2 read bad off=%0h", off), {31'h0, r_bad}, {31'h0, exp_b});
      chk($sformatf("R12 read valid off=%0h", off), {31'h0, r_valid}, 32'h1);
      chk($sformatf("R3 R4 R5 R10 read data off=%0h", off), r_data, exp_d);
    end

    // write sweep (R2 R6 R8 R11 R12)
    for (int off = 0; off < 256; off++) begin
      logic exp_b;
      int   wi;
      wi = off >> 2;
      exp_b = !((off % 4 == 0) && (wi == 37 || wi == 39 || (wi >= 40 && wi <= 43)));
      access(1'b1, 8'(off), {8'(off), 24'h00_0001});
      chk($sformatf("R11 R2 write bad off=%0h", off), {31'h0, r_bad}, {31'h0, exp_b});
      chk($sformatf("R12 write no rsp off=%0h", off), {31'h0, r_valid}, 32'h0);
    end

    access(1'b0, 8'h9C, 32'h0);
    chk("R6 cfg after sweep", r_data, 32'h0000_0001);
    wait_irq("R7 no data no irq", 1'b0);
    chk("R8 out not empty", {31'h0, out_empty}, 32'h0);
    access(1'b0, 8'hB8, 32'h0);
    chk("R5 out status full", r_data, 32'h8000_0004);
    for (int i = 0; i < 4; i++) begin
      chk("R8 out order sweep", out_data, {8'(8'hA0 + 4*i), 24'h00_0001});
      pop_out();
    end
    chk("R8 out empty", {31'h0, out_empty}, 32'h1);
    access(1'b0, 8'hB8, 32'h0);
    chk("R5 out status empty", r_data, 32'h4000_0000);

    // outbound overflow drop (R8)
    for (int i = 0; i < 5; i++) access(1'b1, 8'hA8, 32'h1000 + i);
    access(1'b0, 8'hB8, 32'h0);
    chk("R8 R5 out level after overflow", r_data, 32'h8000_0004);
    for (int i = 0; i < 4; i++) begin
      chk("R8 out order overflow", out_data, 32'h1000 + i);
      pop_out();
    end
    chk("R8 fifth dropped", {31'h0, out_empty}, 32'h1);

    // inbound fill and drain (R3 R4 R5 R6 R7 R9)
    for (int i = 0; i < 5; i++) begin
      push_in(32'hC0DE_0000 + i);
      chk("R9 in_full", {31'h0, in_full}, {31'h0, i >= 3});
    end
    wait_irq("R7 irq with data", 1'b1);
    access(1'b0, 8'h98, 32'h0);
    chk("R5 R9 in status full", r_data, 32'h8000_0004);
    access(1'b0, 8'h90, 32'h0);
    chk("R4 peek head", r_data, 32'hC0DE_0000);
    access(1'b0, 8'h9C, 32'h0);
    chk("R6 cfg pending", r_data, 32'h0000_0011);
    access(1'b0, 8'h84, 32'h0); chk("R3 pop 0", r_data, 32'hC0DE_0000);
    access(1'b0, 8'h88, 32'h0); chk("R3 pop 1", r_data, 32'hC0DE_0001);
    access(1'b0, 8'h8C, 32'h0); chk("R3 pop 2", r_data, 32'hC0DE_0002);
    access(1'b0, 8'h80, 32'h0); chk("R3 pop 3", r_data, 32'hC0DE_0003);
    wait_irq("R7 irq drops when empty", 1'b0);
    access(1'b0, 8'h98, 32'h0);
    chk("R5 in status empty", r_data, 32'h4000_0000);
    access(1'b0, 8'h80, 32'h0);
    chk("R3 empty pop marker", r_data, INV);
    access(1'b0, 8'h90, 32'h0);
    chk("R4 empty peek marker", r_data, INV);

    // enable gating (R6 R7 R10)
    push_in(32'h55);
    wait_irq("R7 irq on push", 1'b1);
    access(1'b1, 8'h9C, 32'hFFFF_FFFE);
    wait_irq("R7 irq disabled", 1'b0);
    access(1'b0, 8'h9C, 32'h0);
    chk("R6 only bit0 stored", r_data, 32'h0000_0010);
    access(1'b1, 8'h9C, 32'hFFFF_FFFF);
    access(1'b0, 8'h9C, 32'h0);
    chk("R6 other bits zero", r_data, 32'h0000_0011);
    wait_irq("R7 irq re-enabled", 1'b1);
    access(1'b1, 8'h94, 32'hFFFF_FFFF);
    access(1'b0, 8'h9C, 32'h0);
    chk("R10 sender write no cfg effect", r_data, 32'h0000_0011);
    access(1'b0, 8'h98, 32'h0);
    chk("R10 sender write no queue effect", r_data, 32'h0000_0001);

    finish_run();
  end
endmodule